// File: doc/BRIEF.md
# Byte Serial Peripheral Interface Controller

This block moves one 8-bit character at a time over a four-wire serial peripheral interface (SPI) link. Software sets it up through three byte-wide registers on a simple read/write bus. A control byte picks the role (master or slave), the idle level of the serial clock, the phase at which data is captured, the bit order, the clock rate and whether completion raises an interrupt. A status byte reports completion. A data byte takes the character to send and returns the character received.

As master, a write to the data register pulls the select line low and produces eight serial clock cycles derived from the system clock. In each cycle one bit goes out on the master-out line and one bit is captured from the master-in line. As slave, the block follows an external clock while its select input is low and drives its output line only during that time. When the eighth cycle is over, the received byte is copied into the data register and a completion flag is set. The flag reaches the interrupt line only when both the local interrupt bit and a chip-wide enable are set.

Top module: `spi_ctrl`

## Requirements
- R1: The control register sits at bus address 0 and can be read and written as a whole byte. It resets to 0x00. Its fields are: bit 7 interrupt enable, bit 6 block enable, bit 5 bit order, bit 4 master role, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate select.
- R2: After reset, the status byte (address 1) reads 0x00, the interrupt output is low, every output-enable is low and the master select output is high.
- R3: When the bit-order bit is 1, bit 0 of a character is shifted first, in both directions. When it is 0, bit 7 is shifted first.
- R4: In master mode the serial clock rests at the level of the polarity bit. A transfer consists of exactly 16 clock edges (8 cycles), and the select output stays low from before the first edge until the last edge.
- R5: With phase 0, the first outgoing bit is already on the data line when select falls. Bits are captured on each leading edge and the outgoing line changes on the trailing edges.
- R6: With phase 1, the outgoing line changes on each leading edge and bits are captured on each trailing edge.
- R7: Rate select 0, 1, 2 and 3 give a half period of the serial clock of 2, 8, 32 and 64 system clocks (divisors 4, 16, 64, 128). The first edge follows the fall of select by one half period.
- R8: When a transfer ends, status bit 7 is set and a read of address 2 returns the received character.
- R9: The completion flag clears when the status byte is read while the flag is set and the data register is accessed afterwards. A pulse on the interrupt acknowledge input also clears it.
- R10: The interrupt output is high exactly when the completion flag, the interrupt enable bit and the global interrupt enable input are all set.
- R11: While the enable bit is 0, no output-enable is asserted and a data write starts no transfer: select stays high and the flag stays clear.
- R12: In slave mode (enable 1, master 0), a transfer is clocked by the external clock while the external select is low. The input line is captured, the slave output follows the selected phase and bit order, and the slave output-enable is high only while selected.
- R13: A data write made while a master transfer runs neither alters the bits being sent nor starts a further transfer afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| glob_irq_en | input | 1 | Chip-wide interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the completion flag |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for the serial clock |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Output enable for master data out |
| mosi_i | input | 1 | Data in from the master, used in slave mode |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Output enable for slave data out |
| miso_i | input | 1 | Data in from the slave, used in master mode |
| ss_n_o | output | 1 | Active-low select driven in master mode |
| ss_n_oe | output | 1 | Output enable for the select line |
| ss_n_i | input | 1 | Active-low select received in slave mode |

## Verification
Master transfers are run in all four polarity and phase combinations. Each combination uses a different rate and bit order, and each transfer uses asymmetric byte patterns in both directions. A swapped capture edge, a reversed bit order or a wrong divisor therefore shows up as a wrong bit, a wrong received byte or a wrong edge spacing. A bus-functional slave model queues the expected master-out bits and compares them on each capture edge, and it answers with its own byte, which must come back through the data register. Separate runs cover slave mode (driven by an external clock), the disabled state, a data write during a busy transfer, and both ways of clearing the flag, with the global interrupt enable toggled on each side.

// File: rtl/spi_ctl_pkg.sv
`timescale 1ns/1ps
package spi_ctl_pkg;
  localparam int DW        = 8;
  localparam int IDXW      = $clog2(DW) + 1;
  localparam int EDGEW     = $clog2(2 * DW);
  localparam int HALF_W    = 7;

  // Control byte layout: the bit positions are decoded by software.
  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       is_master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // Serial clock half period in system clocks for each rate code.
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate);
    logic [HALF_W-1:0] h;
    case (rate)
      2'd0:    h = HALF_W'(2);
      2'd1:    h = HALF_W'(8);
      2'd2:    h = HALF_W'(32);
      default: h = HALF_W'(64);
    endcase
    return h;
  endfunction

  // Bit sent in slot idx of a character for the chosen order.
  function automatic logic pick_bit(input logic [DW-1:0] b,
                                    input logic [IDXW-1:0] idx,
                                    input logic lsb);
    logic [IDXW-2:0] i;
    i = idx[IDXW-2:0];
    return lsb ? b[i] : b[~i];
  endfunction

  // Place a captured bit into the receive word for the chosen order.
  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] rx,
                                             input logic s,
                                             input logic lsb);
    return lsb ? {s, rx[DW-1:1]} : {rx[DW-2:0], s};
  endfunction
endpackage

// File: rtl/spi_rate_gen.sv
`timescale 1ns/1ps
module spi_rate_gen
  import spi_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half_m1;

  assign half_m1 = half_period(rate) - 1'b1;
  assign tick    = run && (cnt >= half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  // R7: the shortest half period is two clocks, so ticks never abut.
  a_r7_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spi_bit_engine.sv
`timescale 1ns/1ps
module spi_bit_engine
  import spi_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             ev_lead,
  input  logic             ev_trail,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic [DW-1:0]    tx_byte,
  input  logic             ser_in,
  output logic             busy,
  output logic [EDGEW-1:0] edge_cnt,
  output logic             out_bit,
  output logic             done,
  output logic [DW-1:0]    rx_byte
);
  localparam logic [EDGEW-1:0] LAST_EDGE = EDGEW'(2 * DW - 1);
  localparam logic [IDXW-1:0]  ALL_BITS  = IDXW'(DW);

  logic [DW-1:0]   tx_q;
  logic [IDXW-1:0] bit_idx;
  logic [DW-1:0]   rx_next;
  logic            any_ev, sample_ev, shift_ev, last_ev;

  assign any_ev    = busy && (ev_lead || ev_trail);
  assign sample_ev = busy && (cpha ? ev_trail : ev_lead);
  assign shift_ev  = busy && (cpha ? ev_lead : ev_trail);
  assign last_ev   = any_ev && (edge_cnt == LAST_EDGE);
  assign rx_next   = sample_ev ? shift_in(rx_byte, ser_in, lsb_first) : rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      edge_cnt <= '0;
      out_bit  <= 1'b0;
      done     <= 1'b0;
      rx_byte  <= '0;
      tx_q     <= '0;
      bit_idx  <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy     <= 1'b0;
        edge_cnt <= '0;
      end else if (start && !busy) begin
        busy     <= 1'b1;
        edge_cnt <= '0;
        tx_q     <= tx_byte;
        if (!cpha) begin
          out_bit <= pick_bit(tx_byte, '0, lsb_first);
          bit_idx <= IDXW'(1);
        end else begin
          bit_idx <= '0;
        end
      end else if (any_ev) begin
        rx_byte <= rx_next;
        if (shift_ev && (bit_idx < ALL_BITS)) begin
          out_bit <= pick_bit(tx_q, bit_idx, lsb_first);
          bit_idx <= bit_idx + 1'b1;
        end
        if (last_ev) begin
          busy     <= 1'b0;
          edge_cnt <= '0;
          done     <= 1'b1;
        end else begin
          edge_cnt <= edge_cnt + 1'b1;
        end
      end
    end
  end

  // R4: a finished character has had every one of its bits shifted out.
  a_r4_all_bits_sent: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bit_idx == ALL_BITS));
  // R4: the edge counter rests at zero between transfers.
  a_r4_idle_counter: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (edge_cnt == '0));
  // R8: completion is a single-cycle event.
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/spi_reg_file.sv
`timescale 1ns/1ps
module spi_reg_file
  import spi_ctl_pkg::*;
#(
  parameter int AW = 2,
  parameter logic [AW-1:0] ADDR_CTRL = 2'd0,
  parameter logic [AW-1:0] ADDR_STAT = 2'd1,
  parameter logic [AW-1:0] ADDR_DATA = 2'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          glob_irq_en,
  input  logic          irq_ack,
  input  logic          xfer_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          busy,
  output ctrl_t         ctrl,
  output logic [DW-1:0] tx_buf,
  output logic          data_wr_ok,
  output logic          irq
);
  logic          sel_c, sel_s, sel_d, data_acc;
  logic          flag, armed;
  logic [DW-1:0] rx_buf;

  assign sel_c      = (bus_addr == ADDR_CTRL);
  assign sel_s      = (bus_addr == ADDR_STAT);
  assign sel_d      = (bus_addr == ADDR_DATA);
  assign data_acc   = (bus_wr || bus_rd) && sel_d;
  assign data_wr_ok = bus_wr && sel_d && !busy;
  assign irq        = flag && ctrl.irq_en && glob_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      tx_buf <= '0;
      rx_buf <= '0;
    end else begin
      if (bus_wr && sel_c) ctrl   <= ctrl_t'(bus_wdata);
      if (data_wr_ok)      tx_buf <= bus_wdata;
      if (xfer_done)       rx_buf <= rx_byte;
    end
  end

  // Completion flag: set on done, cleared by status-read-then-data-access or acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (xfer_done) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (irq_ack || (armed && data_acc)) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (bus_rd && sel_s && flag) begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_c)      bus_rdata = ctrl;
    else if (sel_s) bus_rdata = {flag, {(DW-1){1'b0}}};
    else if (sel_d) bus_rdata = rx_buf;
  end

  // R1: a control write is visible in the register on the next cycle.
  a_r1_ctrl_written: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_c) |=> (ctrl == ctrl_t'($past(bus_wdata))));
  // R8: the flag only rises after the engine reports completion.
  a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(xfer_done));
  // R9: the flag only drops through acknowledge or a data access.
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(irq_ack || data_acc));
endmodule

// File: rtl/spi_ctrl.sv
`timescale 1ns/1ps
module spi_ctrl
  import spi_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       glob_irq_en,
  input  logic       irq_ack,
  output logic       irq,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sck_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       miso_i,
  output logic       ss_n_o,
  output logic       ss_n_oe,
  input  logic       ss_n_i
);
  ctrl_t            ctrl;
  logic [DW-1:0]    tx_buf, rx_byte;
  logic             data_wr_ok, busy, done, out_bit, tick;
  logic [EDGEW-1:0] edge_cnt;

  logic             master_mode, slave_mode;
  logic [2:0]       sck_s;
  logic [1:0]       ss_s;
  logic             slv_sel, slv_sel_q, slv_edge, slv_lead, slv_trail;
  logic             master_go, start, abort, ev_lead, ev_trail, ser_in;

  assign master_mode = ctrl.enable && ctrl.is_master;
  assign slave_mode  = ctrl.enable && !ctrl.is_master;

  spi_reg_file #(.AW(2)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .glob_irq_en(glob_irq_en), .irq_ack(irq_ack), .xfer_done(done),
    .rx_byte(rx_byte), .busy(busy), .ctrl(ctrl), .tx_buf(tx_buf),
    .data_wr_ok(data_wr_ok), .irq(irq)
  );

  // Slave-side input synchronisers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s     <= '0;
      ss_s      <= '1;
      slv_sel_q <= 1'b0;
      master_go <= 1'b0;
    end else begin
      sck_s     <= {sck_s[1:0], sck_i};
      ss_s      <= {ss_s[0], ss_n_i};
      slv_sel_q <= slv_sel;
      master_go <= data_wr_ok && master_mode;
    end
  end

  assign slv_sel   = slave_mode && !ss_s[1];
  assign slv_edge  = slv_sel && (sck_s[2] != sck_s[1]);
  assign slv_lead  = slv_edge && (sck_s[1] != ctrl.cpol);
  assign slv_trail = slv_edge && (sck_s[1] == ctrl.cpol);

  spi_rate_gen u_rate (
    .clk(clk), .rst_n(rst_n), .run(busy && master_mode),
    .rate(ctrl.rate), .tick(tick)
  );

  assign start    = master_mode ? master_go : (slv_sel && !slv_sel_q);
  assign abort    = busy && (!ctrl.enable || (!ctrl.is_master && !slv_sel));
  assign ev_lead  = master_mode ? (tick && !edge_cnt[0]) : slv_lead;
  assign ev_trail = master_mode ? (tick && edge_cnt[0])  : slv_trail;
  assign ser_in   = master_mode ? miso_i : mosi_i;

  spi_bit_engine u_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .ev_lead(ev_lead), .ev_trail(ev_trail), .cpha(ctrl.cpha),
    .lsb_first(ctrl.lsb_first), .tx_byte(tx_buf), .ser_in(ser_in),
    .busy(busy), .edge_cnt(edge_cnt), .out_bit(out_bit), .done(done),
    .rx_byte(rx_byte)
  );

  assign sck_o   = ctrl.cpol ^ (busy && master_mode && edge_cnt[0]);
  assign sck_oe  = master_mode;
  assign mosi_o  = out_bit;
  assign mosi_oe = master_mode;
  assign ss_n_o  = !(busy && master_mode);
  assign ss_n_oe = master_mode;
  assign miso_o  = out_bit;
  assign miso_oe = slv_sel;

  // R4: with select high the master clock sits at the polarity level.
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && ss_n_o) |-> (sck_o == ctrl.cpol));
  // R11: a disabled block drives none of its lines.
  a_r11_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.enable |-> !(sck_oe || mosi_oe || ss_n_oe || miso_oe));
endmodule

// File: tb/tb_spi_ctrl.sv
`timescale 1ns/1ps
module tb_spi_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       glob_irq_en = 1'b1, irq_ack = 1'b0, irq;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_n_o, ss_n_oe;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  logic       miso_i = 1'b0;

  spi_ctrl dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench model of the attached slave
  logic       exp_q[$];
  logic       b_cpol = 0, b_cpha = 0, b_lsb = 0;
  int         b_half = 2;
  logic [7:0] slave_byte = '0;
  logic       prev_sck = 0, prev_ss = 1;
  int         mon_edges = 0, mon_idx = 0, last_cyc = 0;
  bit         spacing_bad = 0;

  function automatic logic sbit(input int i);
    return b_lsb ? slave_byte[i] : slave_byte[7-i];
  endfunction

  // Monitor: pops expected master-out bits on capture edges and answers on miso.
  always @(negedge clk) begin
    if (ss_n_oe && prev_ss && !ss_n_o) begin
      mon_edges = 0; mon_idx = 0; last_cyc = cyc; spacing_bad = 0;
      if (!b_cpha) begin miso_i = sbit(0); mon_idx = 1; end
    end else if (ss_n_oe && !prev_ss && (sck_o != prev_sck)) begin
      logic lead;
      lead = (sck_o != b_cpol);
      if (cyc - last_cyc != b_half) spacing_bad = 1;
      last_cyc = cyc;
      mon_edges++;
      if (lead != b_cpha) begin
        if (exp_q.size() == 0) check(0, "R5 R6 unexpected capture edge", 0, 1);
        else begin
          logic e;
          e = exp_q.pop_front();
          check(mosi_o === e, b_cpha ? "R6 master-out bit" : "R5 master-out bit", mosi_o, e);
        end
      end else if (mon_idx < 8) begin
        miso_i = sbit(mon_idx);
        mon_idx++;
      end
    end
    prev_sck = sck_o;
    prev_ss  = ss_n_o;
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #0.5 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // Driver: programs a master transfer and queues the bits the slave must see.
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sb, input logic lsb,
                             input logic cpol, input logic cpha, input logic [1:0] rate,
                             input logic ie, input bit poke);
    logic [7:0] st, d;
    int guard;
    b_cpol = cpol; b_cpha = cpha; b_lsb = lsb; slave_byte = sb;
    case (rate)
      2'd0: b_half = 2;
      2'd1: b_half = 8;
      2'd2: b_half = 32;
      default: b_half = 64;
    endcase
    bus_write(2'd0, {ie, 1'b1, lsb, 1'b1, cpol, cpha, rate});
    check(sck_o == cpol, "R4 idle clock level", sck_o, cpol);
    for (int i = 0; i < 8; i++) exp_q.push_back(lsb ? tx[i] : tx[7-i]);
    bus_write(2'd2, tx);
    if (poke) begin
      repeat (8) @(negedge clk);
      bus_write(2'd2, ~tx);
    end
    guard = 0;
    do begin bus_read(2'd1, st); guard++; end while (!st[7] && guard < 5000);
    check(st[7] == 1'b1, "R8 completion flag", st, 8'h80);
    check(mon_edges == 16, "R4 edge count", mon_edges, 16);
    check(!spacing_bad, "R7 half period", b_half, b_half);
    check(exp_q.size() == 0, "R5 R6 all bits captured", exp_q.size(), 0);
    check(sck_o == cpol && ss_n_o == 1'b1, "R4 lines idle after transfer", {sck_o, ss_n_o}, {cpol, 1'b1});
    if (ie) begin
      glob_irq_en = 1'b0; #0.5;
      check(irq == 1'b0, "R10 irq masked by global enable", irq, 0);
      glob_irq_en = 1'b1; #0.5;
      check(irq == 1'b1, "R10 irq raised", irq, 1);
      @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      check(irq == 1'b0, "R9 acknowledge drops irq", irq, 0);
      bus_read(2'd1, st);
      check(st == 8'h00, "R9 flag cleared by acknowledge", st, 0);
      bus_read(2'd2, d);
      check(d == sb, lsb ? "R3 R8 received byte" : "R8 received byte", d, sb);
    end else begin
      check(irq == 1'b0, "R10 irq off without enable bit", irq, 0);
      bus_read(2'd2, d);
      check(d == sb, lsb ? "R3 R8 received byte" : "R8 received byte", d, sb);
      bus_read(2'd1, st);
      check(st == 8'h00, "R9 flag cleared by status then data", st, 0);
    end
    if (poke) begin
      bit stayed;
      stayed = 1;
      for (int k = 0; k < 200; k++) begin @(negedge clk); if (!ss_n_o) stayed = 0; end
      check(stayed, "R13 no second transfer", !stayed, 0);
    end
  endtask

  task automatic slave_xfer(input logic [7:0] mtx, input logic [7:0] stx,
                            input logic cpol, input logic lsb);
    logic [7:0] st, d;
    bus_write(2'd0, {1'b0, 1'b1, lsb, 1'b0, cpol, 1'b0, 2'b00});
    bus_write(2'd2, stx);
    sck_i = cpol; mosi_i = 1'b0;
    repeat (8) @(negedge clk);
    check(miso_oe == 1'b0, "R12 slave output off when unselected", miso_oe, 0);
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    check(miso_oe == 1'b1, "R12 slave output on when selected", miso_oe, 1);
    for (int i = 0; i < 8; i++) begin
      logic eb;
      mosi_i = lsb ? mtx[i] : mtx[7-i];
      repeat (8) @(negedge clk);
      eb = lsb ? stx[i] : stx[7-i];
      check(miso_o == eb, lsb ? "R12 R3 slave-out bit" : "R12 slave-out bit", miso_o, eb);
      sck_i = ~cpol;
      repeat (8) @(negedge clk);
      sck_i = cpol;
    end
    repeat (8) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (8) @(negedge clk);
    check(miso_oe == 1'b0, "R12 slave output released", miso_oe, 0);
    bus_read(2'd1, st);
    check(st[7] == 1'b1, "R12 slave completion", st, 8'h80);
    bus_read(2'd2, d);
    check(d == mtx, "R12 slave received byte", d, mtx);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_read(2'd0, v);
    check(v == 8'h00, "R1 control reset value", v, 0);
    bus_read(2'd1, v);
    check(v == 8'h00, "R2 status reset value", v, 0);
    check(irq == 1'b0, "R2 irq after reset", irq, 0);
    check({sck_oe, mosi_oe, ss_n_oe, miso_oe} == 4'b0, "R2 output enables after reset",
          {sck_oe, mosi_oe, ss_n_oe, miso_oe}, 0);
    check(ss_n_o == 1'b1, "R2 select high after reset", ss_n_o, 1);

    bus_write(2'd0, 8'h5A);
    bus_read(2'd0, v);
    check(v == 8'h5A, "R1 control readback", v, 8'h5A);
    check(sck_oe == 1'b1 && sck_o == 1'b1, "R4 master idle clock high", {sck_oe, sck_o}, 2'b11);

    master_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 0);
    master_xfer(8'h96, 8'h81, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 0);
    master_xfer(8'h1E, 8'hC3, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 0);
    master_xfer(8'h6B, 8'hF0, 1'b1, 1'b1, 1'b1, 2'd3, 1'b1, 1);

    // R11: disabled block
    bus_write(2'd0, 8'h10);
    bus_write(2'd2, 8'hAA);
    repeat (300) @(negedge clk);
    check({sck_oe, mosi_oe, ss_n_oe, miso_oe} == 4'b0, "R11 no output enables",
          {sck_oe, mosi_oe, ss_n_oe, miso_oe}, 0);
    check(ss_n_o == 1'b1, "R11 select stays high", ss_n_o, 1);
    bus_read(2'd1, v);
    check(v == 8'h00, "R11 flag stays clear", v, 0);

    slave_xfer(8'h5C, 8'hA3, 1'b0, 1'b0);
    slave_xfer(8'h2D, 8'h9E, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule